// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block takes two clock sources: a fast primary clock and a slower scan/test clock. It picks one of them and drives six gated copies of that clock. Each copy has its own active-low enable. One active-low common enable stands above all six. A copy runs only when its own enable and the common enable are both low.

Enable requests never act directly on an output. Each output has a gate register that captures its combined enable term on the falling edge of the selected clock. The output is the selected clock ANDed with that register. As a result, an output can start or stop only while the clock is low, and no shortened high pulse can appear. Each output also has a status flag that reports the state of its gate register.

An asynchronous active-low reset clears every gate register, so all outputs are held low until enables are first sampled. The source select may be changed only while every output is disabled.

Top module: `clkfan_top`

## Requirements
- R1: With `sel_i` low, the primary clock `pri_clk_i` drives the outputs. With `sel_i` high, the scan clock `scan_clk_i` drives them.
- R2: Output k carries the selected clock only when `en_ni[k]` and `cen_ni` are both low. Driving either one high makes that output stay low.
- R3: A change on `en_ni` or `cen_ni` during a high phase of the selected clock leaves `on_o` and `clk_o` unchanged until the next falling edge of that clock.
- R4: When an output is disabled during a high phase, the high phase that is already in progress completes in full. The output is low from the next falling edge onward.
- R5: No pulse on any `clk_o` bit is shorter than half a period of the selected clock, except a pulse cut short by reset.
- R6: While `rst_ni` is low, every `on_o` and `clk_o` bit is low, whatever the enable levels. This takes effect at once, without waiting for a clock edge.
- R7: `on_o[k]` is high exactly when output k is gated on. It changes only at a falling edge of the selected clock, and it takes the combined enable term that was present just before that edge.
- R8: A high `cen_ni` turns off all six outputs at the same falling edge.
- R9: Each individual enable affects only its own output bit. Bit k of `en_ni` maps to bit k of `clk_o` and of `on_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk_i | input | 1 | Primary (fast) clock source |
| scan_clk_i | input | 1 | Scan/test clock source |
| sel_i | input | 1 | Source select: 0 selects primary, 1 selects scan |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all gates |
| en_ni | input | 6 | Per-output enables, active low |
| cen_ni | input | 1 | Common enable, active low |
| clk_o | output | 6 | Gated clock outputs |
| on_o | output | 6 | Per-output gate status (1 = running) |

## Verification
Every gating result falls due at the first falling edge of the selected clock after the request.

- The bench drives the enables 1 ns after a rising edge.
- While the clock is still high, it checks that `on_o` and `clk_o` still show the old gate.
- It checks `on_o` 0.5 ns after the falling edge.
- It checks the running clock 1 ns after the following rising edge.

Reset is checked within a fraction of a nanosecond, in mid high phase, to show that it acts without a clock edge. A monitor times every high pulse against half of the selected period.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned NUM_OUT_DEF = 6;

  typedef enum logic {
    SRC_PRI  = 1'b0,
    SRC_SCAN = 1'b1
  } clk_src_e;
endpackage

// File: rtl/clkfan_src_sel.sv
module clkfan_src_sel
  import clkfan_pkg::*;
(
  input  logic pri_clk_i,
  input  logic scan_clk_i,
  input  logic sel_i,
  output logic src_clk_o
);
  clk_src_e src;
  assign src = clk_src_e'(sel_i);
  // select may only change while every gate is closed
  assign src_clk_o = (src == SRC_SCAN) ? scan_clk_i : pri_clk_i;
endmodule

// File: rtl/clkfan_en_merge.sv
module clkfan_en_merge #(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic [NUM_OUT-1:0] en_ni,
  input  logic               cen_ni,
  output logic [NUM_OUT-1:0] want_o
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_bit
    assign want_o[k] = ~en_ni[k] & ~cen_ni;
  end
endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic want_i,
  output logic gclk_o,
  output logic on_o
);
  logic gate_q;

  // falling-edge capture: gate only moves while the clock is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= want_i;
  end

  assign gclk_o = src_clk_i & gate_q;
  assign on_o   = gate_q;
endmodule

// File: rtl/clkfan_top.sv
module clkfan_top
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = NUM_OUT_DEF
) (
  input  logic               pri_clk_i,
  input  logic               scan_clk_i,
  input  logic               sel_i,
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] en_ni,
  input  logic               cen_ni,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] on_o
);
  logic               src_clk;
  logic [NUM_OUT-1:0] want;

  clkfan_src_sel u_src (
    .pri_clk_i (pri_clk_i),
    .scan_clk_i(scan_clk_i),
    .sel_i     (sel_i),
    .src_clk_o (src_clk)
  );

  clkfan_en_merge #(.NUM_OUT(NUM_OUT)) u_merge (
    .en_ni (en_ni),
    .cen_ni(cen_ni),
    .want_o(want)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    clkfan_gate u_gate (
      .src_clk_i(src_clk),
      .rst_ni   (rst_ni),
      .want_i   (want[k]),
      .gclk_o   (clk_o[k]),
      .on_o     (on_o[k])
    );
  end
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int unsigned NUM_OUT = 6
) (
  input logic               src_clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] en_ni,
  input logic               cen_ni,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] on_o
);
  logic [NUM_OUT-1:0] want_c;
  logic               armed_q;

  assign want_c = ~en_ni & {NUM_OUT{~cen_ni}};

  // set once a falling edge has passed since reset
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // just before a falling edge the clock is high: outputs equal the gates
  assert_follow_gate_R7: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    clk_o == on_o);

  // gate shows enable term sampled at previous falling edge
  assert_fall_capture_R3: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    armed_q |-> on_o == $past(want_c));

  assert_common_off_R8: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
    (armed_q && $past(cen_ni)) |-> on_o == '0);

  always @(negedge src_clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R6: assert (on_o == '0 && clk_o == '0);
    end
  end
endmodule

bind clkfan_top clkfan_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .src_clk_i(src_clk),
  .rst_ni   (rst_ni),
  .en_ni    (en_ni),
  .cen_ni   (cen_ni),
  .clk_o    (clk_o),
  .on_o     (on_o)
);

// File: tb/clkfan_top_tb_top.sv
`timescale 1ns/1ps
module clkfan_top_tb_top;
  logic       pri_clk = 1'b0;
  logic       scan_clk = 1'b0;
  logic       sel_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [5:0] en_ni = 6'h3F;
  logic       cen_ni = 1'b1;
  logic [5:0] clk_o;
  logic [5:0] on_o;
  logic       src_b;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int runts = 0;
  logic [5:0] exp_on = '0;

  always #2.5 pri_clk = ~pri_clk;   // 200 MHz
  always #10  scan_clk = ~scan_clk;
  assign src_b = sel_i ? scan_clk : pri_clk;

  clkfan_top dut_i (
    .pri_clk_i (pri_clk),
    .scan_clk_i(scan_clk),
    .sel_i     (sel_i),
    .rst_ni    (rst_ni),
    .en_ni     (en_ni),
    .cen_ni    (cen_ni),
    .clk_o     (clk_o),
    .on_o      (on_o)
  );

  // pulse-width monitor (R5)
  logic [5:0] clk_q = '0;
  realtime    t_rise [6];
  always @(clk_o or rst_ni) begin
    for (int k = 0; k < 6; k++) begin
      if (clk_o[k] && !clk_q[k]) t_rise[k] = $realtime;
      else if (!clk_o[k] && clk_q[k] && rst_ni) begin
        pulses++;
        if ($realtime - t_rise[k] < (sel_i ? 10.0 : 2.5) - 0.01) runts++;
      end
    end
    clk_q = clk_o;
  end

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one enable change applied mid high phase; checks each phase
  task automatic step(input logic [5:0] en, input logic c, input string req);
    logic [5:0] prev, nxt;
    prev = exp_on;
    nxt  = c ? 6'h00 : ~en;
    @(posedge src_b); #1;
    en_ni = en; cen_ni = c;
    #0.5;
    chk({"R3 on_o held until fall / ", req}, on_o, prev);
    chk({"R4 high phase completes / ", req}, clk_o, prev);
    @(negedge src_b); #0.5;
    chk({"R7 on_o after fall / ", req}, on_o, nxt);
    chk({"R4 low after fall / ", req}, clk_o, 6'h00);
    @(posedge src_b); #1;
    chk({"R2 running set / ", req}, clk_o, nxt);
    exp_on = nxt;
  endtask

  task automatic t_reset_state;
    en_ni = 6'h00; cen_ni = 1'b0;
    repeat (4) @(negedge pri_clk);
    #1.5;
    chk("R6 on_o in reset", on_o, 6'h00);
    @(posedge pri_clk); #1;
    chk("R6 clk_o in reset", clk_o, 6'h00);
    en_ni = 6'h3F; cen_ni = 1'b1;
    @(posedge pri_clk); #1;
    rst_ni = 1'b1;
    exp_on = '0;
  endtask

  task automatic t_individual;
    step(6'b111110, 1'b0, "R2 one output");
    step(6'b101010, 1'b0, "R9 alternate");
    step(6'b010101, 1'b0, "R9 inverse");
    step(6'b000000, 1'b0, "R2 all on");
    step(6'b011111, 1'b0, "R4 five off");
  endtask

  task automatic t_common;
    step(6'b000000, 1'b0, "R2 all on again");
    step(6'b000000, 1'b1, "R8 common off");
    step(6'b000000, 1'b0, "R8 common on");
  endtask

  task automatic t_async_reset;
    @(posedge pri_clk); #1;
    chk("R6 pre-reset running", clk_o, 6'h3F);
    rst_ni = 1'b0;
    #0.2;
    chk("R6 clk_o cleared without edge", clk_o, 6'h00);
    chk("R6 on_o cleared without edge", on_o, 6'h00);
    @(posedge pri_clk); #1;
    rst_ni = 1'b1;
    #0.5;
    chk("R6 stays off until fall", clk_o, 6'h00);
    @(negedge pri_clk); #0.5;
    chk("R7 gate restored after reset", on_o, 6'h3F);
    exp_on = 6'h3F;
  endtask

  task automatic t_scan;
    step(6'h3F, 1'b1, "R8 all off before switch");
    @(negedge pri_clk); #1;
    sel_i = 1'b1;
    repeat (2) @(negedge scan_clk);
    step(6'b111011, 1'b0, "R1 scan source");
    @(posedge scan_clk); #6;
    chk("R1 follows scan high", clk_o, 6'b000100);
    @(negedge scan_clk); #2;
    chk("R1 follows scan low", clk_o, 6'b000000);
    step(6'b111011, 1'b1, "R8 scan off");
    @(negedge scan_clk); #1;
    sel_i = 1'b0;
    repeat (2) @(negedge pri_clk);
    step(6'b110111, 1'b0, "R1 primary back");
    @(posedge pri_clk); #1.5;
    chk("R1 primary high", clk_o, 6'b001000);
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    t_reset_state();
    t_individual();
    t_common();
    t_async_reset();
    t_scan();
    repeat (2) @(posedge pri_clk);
    checks++;
    if (runts != 0 || pulses == 0) begin
      errors++;
      $display("FAIL R5 runt pulses act=%0d of %0d exp=0", runts, pulses);
    end
    summary();
    $finish;
  end
endmodule